// File: doc/BRIEF.md
# Streaming ROI Uniformity Analyzer

This block watches a raster pixel stream, in which every pixel carries its own row and column coordinates. It cuts a rectangular analysis window into a grid of equal square regions and sums the samples that fall in each region. When the last pixel of a region arrives, it turns the region total into a mean. It then subtracts a dark reference level, which is the average of the overclocked columns of the line, from that mean and emits the result as the signal of that region.

Over a frame the block keeps the largest and smallest region signal. When the last region has been evaluated, it reports both values together with their difference, which is the peak-to-peak non-uniformity of the frame. A frame-start pulse opens each frame and supplies the reference level for that frame.

Only one horizontal band of region accumulators exists at any time. Results therefore leave the block band by band, in raster order.

Top module: `roi_uniformity_analyzer`

## Requirements
- R1: Only pixels with `pix_valid` high whose column lies in [ORIGIN_X, ORIGIN_X+GRID_X*REG_SZ) and whose row lies in [ORIGIN_Y, ORIGIN_Y+GRID_Y*REG_SZ) contribute. Every other pixel has no effect on any output.
- R2: Region (x, y) covers columns ORIGIN_X+x*REG_SZ to ORIGIN_X+x*REG_SZ+REG_SZ-1 and rows ORIGIN_Y+y*REG_SZ to ORIGIN_Y+y*REG_SZ+REG_SZ-1. x counts left to right from 0 and y counts top to bottom from 0.
- R3: `reg_signal` is the two's-complement value floor(region sum / (REG_SZ*REG_SZ)) minus the reference level, PIX_W+1 bits wide.
- R4: Exactly one result (`reg_valid` high for one cycle) is emitted per region, with `reg_x`/`reg_y` set to the region's indices. Results come in raster order: all regions of band y leave left to right before band y+1, and each band leaves once its last row has arrived.
- R5: `ocl_avg` is captured only in the cycle `frame_start` is high. A change of `ocl_avg` later in the frame does not alter that frame's results.
- R6: At frame end `sig_max` and `sig_min` hold the largest and smallest region signal of the frame, compared as signed values, and `sig_p2p` holds their difference as an unsigned value. These outputs keep their values until the next frame ends.
- R7: `frame_done` is high for exactly one cycle. That cycle is the one right after the result of the last region (x=GRID_X-1, y=GRID_Y-1).
- R8: After reset, `reg_valid` and `frame_done` are low, and `sig_max`, `sig_min` and `sig_p2p` are zero.
- R9: `frame_start` discards partial region sums and the running extremes, so an aborted frame leaves no trace in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse opening a frame |
| ocl_avg | input | PIX_W | Overclock reference level, captured at frame_start |
| pix_valid | input | 1 | Pixel qualifier |
| pix_row | input | COORD_W | Row coordinate of the pixel |
| pix_col | input | COORD_W | Column coordinate of the pixel |
| pix_data | input | PIX_W | Pixel sample |
| reg_valid | output | 1 | Region result strobe |
| reg_x | output | max(1,clog2(GRID_X)) | Region column index |
| reg_y | output | max(1,clog2(GRID_Y)) | Region row index |
| reg_signal | output | PIX_W+1 | Signed region signal |
| sig_max | output | PIX_W+1 | Largest region signal of the last frame |
| sig_min | output | PIX_W+1 | Smallest region signal of the last frame |
| sig_p2p | output | PIX_W+1 | sig_max minus sig_min |
| frame_done | output | 1 | Frame result strobe |

## Verification
The bench builds the block with 3x3 regions on a 3 by 2 grid, a window origin of (2,1) and 6-bit coordinates. A whole frame, margins included, is then about one hundred pixels. This makes a full frame short enough to repeat many times. Because the region area of 9 is not a power of two, the reciprocal-multiply mean is the path under test, and its floor rounding shows in gradient patterns. Sample values reach both ends of the 14-bit range, which drives the signed signal to its extremes. Aborted frames, coordinate-carrying gaps and margin pixels set to full scale all land within the small frame.

// File: rtl/roi_pkg.sv
package roi_pkg;

   // Ceiling of 2^shift / n, used as the fixed reciprocal for the mean.
   function automatic logic [63:0] recip_ceil(input int unsigned n, input int unsigned shift);
      logic [63:0] num;
      num = (64'd1 << shift) + 64'(n) - 64'd1;
      return num / 64'(n);
   endfunction

   // Index width that never collapses to zero bits.
   function automatic int unsigned idx_width(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/roi_window_map.sv
module roi_window_map #(
   parameter int PIX_W    = 14,
   parameter int COORD_W  = 13,
   parameter int REG_SZ   = 136,
   parameter int GRID_X   = 36,
   parameter int GRID_Y   = 24,
   parameter int ORIGIN_X = 13,
   parameter int ORIGIN_Y = 13,
   parameter int GX_W     = 6,
   parameter int GY_W     = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] pix_row,
   input  logic [COORD_W-1:0] pix_col,
   input  logic [PIX_W-1:0]   pix_data,
   output logic               w_valid,
   output logic [GX_W-1:0]    w_rx,
   output logic [GY_W-1:0]    w_ry,
   output logic               w_last_x,
   output logic               w_last_y,
   output logic [PIX_W-1:0]   w_data
);
   localparam int HI_X = ORIGIN_X + GRID_X * REG_SZ;
   localparam int HI_Y = ORIGIN_Y + GRID_Y * REG_SZ;

   logic               in_col, in_row, take;
   logic [COORD_W-1:0] rel_c, rel_r;

   assign in_col = (pix_col >= COORD_W'(ORIGIN_X)) && (pix_col < COORD_W'(HI_X));
   assign in_row = (pix_row >= COORD_W'(ORIGIN_Y)) && (pix_row < COORD_W'(HI_Y));
   assign take   = pix_valid && in_col && in_row;
   assign rel_c  = pix_col - COORD_W'(ORIGIN_X);
   assign rel_r  = pix_row - COORD_W'(ORIGIN_Y);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_valid  <= 1'b0;
         w_rx     <= '0;
         w_ry     <= '0;
         w_last_x <= 1'b0;
         w_last_y <= 1'b0;
         w_data   <= '0;
      end else begin
         w_valid <= take;
         if (take) begin
            w_rx     <= GX_W'(rel_c / COORD_W'(REG_SZ));
            w_ry     <= GY_W'(rel_r / COORD_W'(REG_SZ));
            w_last_x <= ((rel_c % COORD_W'(REG_SZ)) == COORD_W'(REG_SZ - 1));
            w_last_y <= ((rel_r % COORD_W'(REG_SZ)) == COORD_W'(REG_SZ - 1));
            w_data   <= pix_data;
         end
      end
   end
endmodule

// File: rtl/roi_band_accum.sv
module roi_band_accum #(
   parameter int PIX_W  = 14,
   parameter int SUM_W  = 29,
   parameter int GRID_X = 36,
   parameter int GRID_Y = 24,
   parameter int GX_W   = 6,
   parameter int GY_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             w_valid,
   input  logic [GX_W-1:0]  w_rx,
   input  logic [GY_W-1:0]  w_ry,
   input  logic             w_last_x,
   input  logic             w_last_y,
   input  logic [PIX_W-1:0] w_data,
   output logic             cl_valid,
   output logic [SUM_W-1:0] cl_sum,
   output logic [GX_W-1:0]  cl_rx,
   output logic [GY_W-1:0]  cl_ry,
   output logic             cl_last
);
   logic [SUM_W-1:0] acc_view [GRID_X];
   logic             closing;

   assign closing = w_valid && w_last_x && w_last_y;

   for (genvar g = 0; g < GRID_X; g++) begin : g_col
      logic [SUM_W-1:0] acc;
      logic             hit;
      assign hit = w_valid && (w_rx == GX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     acc <= '0;
         else if (clear)                 acc <= '0;
         else if (hit && closing)        acc <= '0;
         else if (hit)                   acc <= acc + SUM_W'(w_data);
      end
      assign acc_view[g] = acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cl_valid <= 1'b0;
         cl_sum   <= '0;
         cl_rx    <= '0;
         cl_ry    <= '0;
         cl_last  <= 1'b0;
      end else begin
         cl_valid <= closing && !clear;
         if (closing) begin
            cl_sum  <= acc_view[w_rx] + SUM_W'(w_data);
            cl_rx   <= w_rx;
            cl_ry   <= w_ry;
            cl_last <= (w_rx == GX_W'(GRID_X - 1)) && (w_ry == GY_W'(GRID_Y - 1));
         end
      end
   end
endmodule

// File: rtl/roi_signal_calc.sv
module roi_signal_calc #(
   parameter int PIX_W   = 14,
   parameter int SUM_W   = 29,
   parameter int REG_PIX = 18496,
   parameter int GX_W    = 6,
   parameter int GY_W    = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic [PIX_W-1:0]        ocl_in,
   input  logic                    cl_valid,
   input  logic [SUM_W-1:0]        cl_sum,
   input  logic [GX_W-1:0]         cl_rx,
   input  logic [GY_W-1:0]         cl_ry,
   input  logic                    cl_last,
   output logic                    reg_valid,
   output logic [GX_W-1:0]         reg_x,
   output logic [GY_W-1:0]         reg_y,
   output logic signed [PIX_W:0]   reg_signal,
   output logic                    reg_last
);
   localparam int  LOG_N = $clog2(REG_PIX);
   localparam bit  POW2  = ((REG_PIX & (REG_PIX - 1)) == 0);

   logic [PIX_W-1:0]       ocl_q;
   logic [PIX_W-1:0]       mean;
   logic signed [PIX_W:0]  diff;

   if (POW2) begin : g_shift_mean
      assign mean = PIX_W'(cl_sum >> LOG_N);
   end else begin : g_recip_mean
      localparam int          SHIFT  = SUM_W + LOG_N;
      localparam int          PROD_W = 2 * SUM_W + 1;
      localparam logic [63:0] RECIP  = roi_pkg::recip_ceil(REG_PIX, SHIFT);
      logic [PROD_W-1:0] prod;
      logic [PROD_W-1:0] scaled;
      assign prod   = PROD_W'(cl_sum) * PROD_W'(RECIP);
      assign scaled = prod >> SHIFT;
      assign mean   = scaled[PIX_W-1:0];
   end

   assign diff = $signed({1'b0, mean}) - $signed({1'b0, ocl_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ocl_q <= '0;
      else if (frame_start) ocl_q <= ocl_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_valid  <= 1'b0;
         reg_x      <= '0;
         reg_y      <= '0;
         reg_signal <= '0;
         reg_last   <= 1'b0;
      end else begin
         reg_valid <= cl_valid && !frame_start;
         reg_last  <= cl_valid && cl_last && !frame_start;
         if (cl_valid) begin
            reg_x      <= cl_rx;
            reg_y      <= cl_ry;
            reg_signal <= diff;
         end
      end
   end
endmodule

// File: rtl/roi_extreme_track.sv
module roi_extreme_track #(
   parameter int SIG_W = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    reg_valid,
   input  logic                    reg_last,
   input  logic signed [SIG_W-1:0] reg_signal,
   output logic signed [SIG_W-1:0] sig_max,
   output logic signed [SIG_W-1:0] sig_min,
   output logic [SIG_W-1:0]        sig_p2p,
   output logic                    frame_done
);
   localparam logic signed [SIG_W-1:0] MOST_NEG = {1'b1, {(SIG_W-1){1'b0}}};
   localparam logic signed [SIG_W-1:0] MOST_POS = {1'b0, {(SIG_W-1){1'b1}}};

   logic signed [SIG_W-1:0] run_max, run_min, nxt_max, nxt_min;
   logic signed [SIG_W:0]   spread;

   assign nxt_max = (reg_signal > run_max) ? reg_signal : run_max;
   assign nxt_min = (reg_signal < run_min) ? reg_signal : run_min;
   assign spread  = {nxt_max[SIG_W-1], nxt_max} - {nxt_min[SIG_W-1], nxt_min};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_max <= MOST_NEG;
         run_min <= MOST_POS;
      end else if (frame_start) begin
         run_max <= MOST_NEG;
         run_min <= MOST_POS;
      end else if (reg_valid) begin
         run_max <= nxt_max;
         run_min <= nxt_min;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_max    <= '0;
         sig_min    <= '0;
         sig_p2p    <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= reg_valid && reg_last && !frame_start;
         if (reg_valid && reg_last && !frame_start) begin
            sig_max <= nxt_max;
            sig_min <= nxt_min;
            sig_p2p <= spread[SIG_W-1:0];
         end
      end
   end
endmodule

// File: rtl/roi_uniformity_analyzer.sv
module roi_uniformity_analyzer #(
   parameter int PIX_W    = 14,
   parameter int COORD_W  = 13,
   parameter int REG_SZ   = 136,
   parameter int GRID_X   = 36,
   parameter int GRID_Y   = 24,
   parameter int ORIGIN_X = 13,
   parameter int ORIGIN_Y = 13
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     frame_start,
   input  logic [PIX_W-1:0]                         ocl_avg,
   input  logic                                     pix_valid,
   input  logic [COORD_W-1:0]                       pix_row,
   input  logic [COORD_W-1:0]                       pix_col,
   input  logic [PIX_W-1:0]                         pix_data,
   output logic                                     reg_valid,
   output logic [roi_pkg::idx_width(GRID_X)-1:0]    reg_x,
   output logic [roi_pkg::idx_width(GRID_Y)-1:0]    reg_y,
   output logic signed [PIX_W:0]                    reg_signal,
   output logic signed [PIX_W:0]                    sig_max,
   output logic signed [PIX_W:0]                    sig_min,
   output logic [PIX_W:0]                           sig_p2p,
   output logic                                     frame_done
);
   localparam int REG_PIX = REG_SZ * REG_SZ;
   localparam int SUM_W   = PIX_W + $clog2(REG_PIX);
   localparam int SIG_W   = PIX_W + 1;
   localparam int GX_W    = roi_pkg::idx_width(GRID_X);
   localparam int GY_W    = roi_pkg::idx_width(GRID_Y);

   // Elaboration-time parameter checks
   if (REG_SZ < 2) begin : g_bad_size
      $error("REG_SZ must be at least 2");
   end
   if (PIX_W < 2 || PIX_W > 24) begin : g_bad_pix
      $error("PIX_W out of range");
   end
   if (SUM_W + $clog2(REG_PIX) > 63) begin : g_bad_shift
      $error("reciprocal scale exceeds 63 bits");
   end
   if (ORIGIN_X + GRID_X * REG_SZ >= (1 << COORD_W) ||
       ORIGIN_Y + GRID_Y * REG_SZ >= (1 << COORD_W)) begin : g_bad_coord
      $error("analysis window does not fit the coordinate width");
   end

   logic             w_valid, w_last_x, w_last_y;
   logic [GX_W-1:0]  w_rx;
   logic [GY_W-1:0]  w_ry;
   logic [PIX_W-1:0] w_data;

   logic             cl_valid, cl_last;
   logic [SUM_W-1:0] cl_sum;
   logic [GX_W-1:0]  cl_rx;
   logic [GY_W-1:0]  cl_ry;

   logic             s_last;

   roi_window_map #(
      .PIX_W(PIX_W), .COORD_W(COORD_W), .REG_SZ(REG_SZ), .GRID_X(GRID_X),
      .GRID_Y(GRID_Y), .ORIGIN_X(ORIGIN_X), .ORIGIN_Y(ORIGIN_Y),
      .GX_W(GX_W), .GY_W(GY_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_row(pix_row),
      .pix_col(pix_col), .pix_data(pix_data), .w_valid(w_valid), .w_rx(w_rx),
      .w_ry(w_ry), .w_last_x(w_last_x), .w_last_y(w_last_y), .w_data(w_data)
   );

   roi_band_accum #(
      .PIX_W(PIX_W), .SUM_W(SUM_W), .GRID_X(GRID_X), .GRID_Y(GRID_Y),
      .GX_W(GX_W), .GY_W(GY_W)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(frame_start), .w_valid(w_valid),
      .w_rx(w_rx), .w_ry(w_ry), .w_last_x(w_last_x), .w_last_y(w_last_y),
      .w_data(w_data), .cl_valid(cl_valid), .cl_sum(cl_sum), .cl_rx(cl_rx),
      .cl_ry(cl_ry), .cl_last(cl_last)
   );

   roi_signal_calc #(
      .PIX_W(PIX_W), .SUM_W(SUM_W), .REG_PIX(REG_PIX), .GX_W(GX_W), .GY_W(GY_W)
   ) u_sig (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ocl_in(ocl_avg),
      .cl_valid(cl_valid), .cl_sum(cl_sum), .cl_rx(cl_rx), .cl_ry(cl_ry),
      .cl_last(cl_last), .reg_valid(reg_valid), .reg_x(reg_x), .reg_y(reg_y),
      .reg_signal(reg_signal), .reg_last(s_last)
   );

   roi_extreme_track #(
      .SIG_W(SIG_W)
   ) u_ext (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .reg_valid(reg_valid),
      .reg_last(s_last), .reg_signal(reg_signal), .sig_max(sig_max),
      .sig_min(sig_min), .sig_p2p(sig_p2p), .frame_done(frame_done)
   );
endmodule

// File: rtl/roi_uniformity_checker.sv
module roi_uniformity_checker #(
   parameter int PIX_W  = 14,
   parameter int GRID_X = 36,
   parameter int GRID_Y = 24
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  reg_valid,
   input logic [roi_pkg::idx_width(GRID_X)-1:0] reg_x,
   input logic [roi_pkg::idx_width(GRID_Y)-1:0] reg_y,
   input logic signed [PIX_W:0]                 sig_max,
   input logic signed [PIX_W:0]                 sig_min,
   input logic                                  frame_done
);
   localparam int GX_W = roi_pkg::idx_width(GRID_X);
   localparam int GY_W = roi_pkg::idx_width(GRID_Y);

   // R7: the last region result is followed by the frame strobe
   a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_x == GX_W'(GRID_X - 1) && reg_y == GY_W'(GRID_Y - 1)) |=> frame_done);

   // R7: the frame strobe lasts one cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R7: the frame strobe only comes right after a region result
   a_r7_done_after_result: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(reg_valid));

   // R6: reported extremes are ordered
   a_r6_max_ge_min: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (sig_max >= sig_min));

   // R4: region indices stay inside the grid
   a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> (reg_x <= GX_W'(GRID_X - 1) && reg_y <= GY_W'(GRID_Y - 1)));
endmodule

bind roi_uniformity_analyzer roi_uniformity_checker #(
   .PIX_W(PIX_W), .GRID_X(GRID_X), .GRID_Y(GRID_Y)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_x(reg_x),
   .reg_y(reg_y), .sig_max(sig_max), .sig_min(sig_min), .frame_done(frame_done)
);

// File: tb/roi_uniformity_analyzer_test.sv
module roi_uniformity_analyzer_test;
   localparam int PW = 14, CW = 6, RS = 3, GX = 3, GY = 2, OX = 2, OY = 1;
   localparam int ROWS = OY + GY * RS + 1;
   localparam int COLS = OX + GX * RS + 2;
   localparam int NREG = GX * GY;

   // pat, base, ocl, gaps, ocl_change, exp_max, exp_min, exp_p2p
   localparam int VEC [6][8] = '{
      '{0, 1000, 1000,  0, 0,      0,      0,    0},
      '{1,  500,  600,  1, 0,     20,   -100,  120},
      '{2,  200,   50,  0, 0,    155,    155,    0},
      '{3,  100,  200,  0, 1,   4900,   -100, 5000},
      '{1, 16000,   0,  1, 1,  16120,  16000,  120},
      '{0,    0, 16383, 0, 0, -16383, -16383,    0}
   };

   logic clk = 0, rst_n = 0, frame_start = 0, pix_valid = 0;
   logic [PW-1:0] ocl_avg = '0, pix_data = '0;
   logic [CW-1:0] pix_row = '0, pix_col = '0;
   logic reg_valid, frame_done;
   logic [1:0] reg_x;
   logic       reg_y;
   logic signed [PW:0] reg_signal, sig_max, sig_min;
   logic [PW:0] sig_p2p;

   int checks = 0, errors = 0;
   int ev_cnt = 0, done_cnt = 0, done_late = 0;
   int got_x [16], got_y [16], got_s [16];
   bit prev_last = 0;

   always #2 clk = ~clk;

   roi_uniformity_analyzer #(.PIX_W(PW), .COORD_W(CW), .REG_SZ(RS), .GRID_X(GX),
      .GRID_Y(GY), .ORIGIN_X(OX), .ORIGIN_Y(OY)) uut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ocl_avg(ocl_avg),
      .pix_valid(pix_valid), .pix_row(pix_row), .pix_col(pix_col), .pix_data(pix_data),
      .reg_valid(reg_valid), .reg_x(reg_x), .reg_y(reg_y), .reg_signal(reg_signal),
      .sig_max(sig_max), .sig_min(sig_min), .sig_p2p(sig_p2p), .frame_done(frame_done));

   always @(negedge clk) begin
      if (reg_valid) begin
         if (ev_cnt < 16) begin
            got_x[ev_cnt] = int'(reg_x);
            got_y[ev_cnt] = int'(reg_y);
            got_s[ev_cnt] = int'(reg_signal);
         end
         ev_cnt++;
      end
      if (frame_done) begin
         done_cnt++;
         if (!prev_last) done_late++;
      end
      prev_last = reg_valid && reg_x == 2'(GX - 1) && reg_y == 1'(GY - 1);
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pix_val(input int pat, input int base, input int r, input int c);
      int rx, ry, dx, dy;
      if (r < OY || r >= OY + GY * RS || c < OX || c >= OX + GX * RS) return 16383;
      rx = (c - OX) / RS; dx = (c - OX) % RS;
      ry = (r - OY) / RS; dy = (r - OY) % RS;
      case (pat)
         1: return base + 10 * rx + 100 * ry;
         2: return base + dx + 4 * dy;
         3: return base + ((rx == GX - 1 && ry == GY - 1) ? 5000 : 0);
         default: return base;
      endcase
   endfunction

   function automatic int model_sig(input int pat, input int base, input int ocl,
                                    input int rx, input int ry);
      int sum = 0;
      for (int dy = 0; dy < RS; dy++)
         for (int dx = 0; dx < RS; dx++)
            sum += pix_val(pat, base, OY + ry * RS + dy, OX + rx * RS + dx);
      return sum / (RS * RS) - ocl;
   endfunction

   task automatic drive_frame(input int pat, input int base, input int ocl,
                              input int gaps, input int chg, input int row_lim);
      @(negedge clk);
      ev_cnt = 0; done_cnt = 0; done_late = 0;
      frame_start = 1; ocl_avg = PW'(ocl); pix_valid = 0;
      @(negedge clk);
      frame_start = 0;
      if (chg != 0) ocl_avg = PW'((ocl + 777) % 16384);
      for (int r = 0; r < ROWS && r < row_lim; r++) begin
         for (int c = 0; c < COLS; c++) begin
            pix_valid = 1; pix_row = CW'(r); pix_col = CW'(c);
            pix_data = PW'(pix_val(pat, base, r, c));
            @(negedge clk);
            if (gaps != 0 && (c % 4) == 1) begin
               pix_valid = 0; pix_row = CW'(OY); pix_col = CW'(OX); pix_data = '1;
               @(negedge clk);
            end
         end
      end
      pix_valid = 0;
      repeat (8) @(negedge clk);
   endtask

   task automatic check_frame(input int pat, input int base, input int ocl,
                              input int emax, input int emin, input int ep2p);
      check(ev_cnt == NREG, "R4 result count", ev_cnt, NREG);
      for (int i = 0; i < NREG && i < ev_cnt; i++) begin
         check(got_x[i] == i % GX, "R4 raster x", got_x[i], i % GX);
         check(got_y[i] == i / GX, "R4 raster y", got_y[i], i / GX);
         check(got_s[i] == model_sig(pat, base, ocl, i % GX, i / GX),
               "R2/R3/R5 region signal", got_s[i], model_sig(pat, base, ocl, i % GX, i / GX));
      end
      check(done_cnt == 1, "R7 done count", done_cnt, 1);
      check(done_late == 0, "R7 done timing", done_late, 0);
      check(int'(sig_max) == emax, "R6/R1 max", int'(sig_max), emax);
      check(int'(sig_min) == emin, "R6/R1 min", int'(sig_min), emin);
      check(int'(sig_p2p) == ep2p, "R6 p2p", int'(sig_p2p), ep2p);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check(reg_valid == 0, "R8 reg_valid", int'(reg_valid), 0);
      check(frame_done == 0, "R8 frame_done", int'(frame_done), 0);
      check(sig_max == 0, "R8 sig_max", int'(sig_max), 0);
      check(sig_p2p == 0, "R8 sig_p2p", int'(sig_p2p), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 6; v++) begin
         drive_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1000);
         check_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][5], VEC[v][6], VEC[v][7]);
      end

      // R9: aborted frame (band 0 incomplete) must not leak into the next one
      drive_frame(3, 9000, 0, 0, 0, 3);
      check(ev_cnt == 0, "R9 partial frame emits nothing", ev_cnt, 0);
      check(int'(sig_p2p) == 0, "R9 outputs held after abort", int'(sig_p2p), 0);
      drive_frame(0, 300, 100, 0, 0, 1000);
      check_frame(0, 300, 100, 200, 200, 0);

      // R9: abort after band 0 closed, then a new frame with different extremes
      drive_frame(3, 50, 0, 0, 0, 5);
      check(done_cnt == 0, "R9 no done on abort", done_cnt, 0);
      drive_frame(2, 7000, 7005, 1, 1, 1000);
      check_frame(2, 7000, 7005, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule